// File: doc/BRIEF.md
# Command list sequencer with event wait

This block steps through a list of 32-bit command words held in memory and carries them out one after another. A start strobe loads a list address. The sequencer then reads one word at a time through a simple request and data-valid read port, decodes the opcode and acts on it. The commands are: set or clear bits of a task-private signal vector; stall until a combination of live events and private signals holds; a check-late form of that stall that reports when the condition was already met; and handing a 26-bit section mask to a companion upload unit, then waiting for it to finish.

Stalls combine the selected bits with either AND or OR, and the result can be inverted. A watchdog timer guards each stall. It counts clock cycles, vertical sync rising edges, or both, up to a programmable limit. When the limit is reached the task stops, a timeout flag is set, and, if enabled, a one-cycle interrupt pulse is issued. The private signal vector holds a copy of a set of live status bits. Commands may change this copy, but a live status bit that is high always forces its copy bit high again. The task ends on a timeout or on an unknown opcode, which sets an error flag.

States: IDLE (no task), FETCH (read request held until data-valid), EXEC (decode the latched word for one cycle), WAIT (stall on the condition with the timer running), UPLOAD (hand-off in progress). Transitions: IDLE to FETCH on start; FETCH to EXEC on data-valid; EXEC to FETCH for signal commands and for a check-late found true; EXEC to WAIT for a stall, or for a check-late found false; EXEC to UPLOAD for the upload command; EXEC to IDLE for an unknown opcode; WAIT to FETCH when the condition holds; WAIT to IDLE on timeout; UPLOAD to FETCH on upload done.

Top module: `cmdseq_top`

## Requirements
- R1: A word holds its opcode in bits 31:28 and a command field in bits 27:0. Opcodes are 0 clear-signal, 1 set-signal, 2 wait, 3 check-late, 4 upload. Words are read starting at the start address, with the address rising by 4 after each accepted word. The request stays high, with the address held stable, until data-valid arrives.
- R2: Set-signal ORs field bits [NSIG-1:0] into the private signal vector, and clear-signal removes them. The no-operation word 0x00000000 is a clear with an empty mask and leaves the vector unchanged.
- R3: A live status bit that is high forces its private copy bit high on the next cycle, even while a clear-signal for that bit executes.
- R4: A stall tests the 26-bit vector made of live events (bits 25:NSIG) above the private signals (bits NSIG-1:0), with field bits 25:0 as the select mask. When field bit 27 is 0, every selected bit must be 1.
- R5: When field bit 27 is 1, any selected bit at 1 satisfies the stall.
- R6: When field bit 26 is 1, the stall ends once the combined condition is false.
- R7: The stall timer counts clock cycles when the clock base is enabled, and vsync rising edges when the vsync base is enabled. It expires when the count reaches a nonzero limit. A limit of 0 means the stall never times out.
- R8: On expiry the task stops (busy low), the timeout flag is set, and a single-cycle interrupt pulse is issued only when interrupts are enabled.
- R9: A check-late whose condition already holds at decode sets the late flag and continues without stalling. Otherwise it stalls like a wait and leaves the late flag clear.
- R10: Upload holds the upload request, with the mask equal to field bits 25:0, until upload-done, and then continues with the next word.
- R11: An unknown opcode (5 to 15) sets the error flag and stops the task.
- R12: After reset the block is idle with no request, all flags low and the signal vector zero. A start clears the timeout, late and error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, used when idle |
| start_addr_i | input | 32 | Byte address of the first command word |
| evt_i | input | 26-NSIG | Live event bits |
| stat_i | input | NSIG | Live status bits that set the private copy |
| vsync_i | input | 1 | Vertical sync, rising edges counted |
| tmo_limit_i | input | TW | Stall timeout limit, 0 disables |
| tmo_clk_en_i | input | 1 | Count clock cycles |
| tmo_vs_en_i | input | 1 | Count vsync rising edges |
| irq_en_i | input | 1 | Interrupt enable for timeout |
| req_o | output | 1 | Read request |
| addr_o | output | 32 | Read word address |
| rdata_i | input | 32 | Read data |
| rvalid_i | input | 1 | Read data valid |
| upl_req_o | output | 1 | Upload request to companion unit |
| upl_mask_o | output | 26 | Upload section mask |
| upl_done_i | input | 1 | Upload finished |
| sig_o | output | NSIG | Task-private signal vector |
| tmo_flag_o | output | 1 | Timeout status |
| late_flag_o | output | 1 | Late status |
| err_flag_o | output | 1 | Unknown opcode status |
| irq_o | output | 1 | Interrupt pulse |
| busy_o | output | 1 | Task running |

## Verification
Two things can act on one private signal bit in the same cycle: a clear-signal command executing, and the live status bit for that position being high. The bench holds a status bit high across a program that clears that bit. The copy bit must still read 1 afterwards. When the status is low, the same clear must remove the bit, and a later one-cycle status pulse must set it again. A stall that meets its condition in the same cycle as expiry counts as satisfied. The bench therefore judges timeouts only against conditions that never hold, and checks that the stop falls within a few cycles of the limit.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
    localparam int EVW      = 26;
    localparam int MODE_BIT = 27;
    localparam int INV_BIT  = 26;

    localparam logic [3:0] OPC_CLR  = 4'h0;
    localparam logic [3:0] OPC_SET  = 4'h1;
    localparam logic [3:0] OPC_WAIT = 4'h2;
    localparam logic [3:0] OPC_LATE = 4'h3;
    localparam logic [3:0] OPC_UPLD = 4'h4;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_EXEC  = 3'd2,
        S_WAIT  = 3'd3,
        S_UPLD  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/cmdseq_fetch.sv
module cmdseq_fetch #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic          adv_i,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] STEP = AW'(4);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= base_i;
        end else if (adv_i) begin
            addr_q <= addr_q + STEP;
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/cmdseq_evcond.sv
module cmdseq_evcond #(
    parameter int W = 26
) (
    input  logic [W-1:0] vec_i,
    input  logic [W-1:0] sel_i,
    input  logic         any_i,
    input  logic         inv_i,
    output logic         met_o
);
    logic all_ok;
    logic any_ok;
    logic raw;

    always_comb begin
        all_ok = &(vec_i | ~sel_i);
        any_ok = |(vec_i & sel_i);
        raw    = any_i ? any_ok : all_ok;
        met_o  = raw ^ inv_i;
    end
endmodule

// File: rtl/cmdseq_timer.sv
module cmdseq_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic          clk_en_i,
    input  logic          vs_en_i,
    input  logic          vsync_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);
    localparam logic [TW-1:0] CMAX = '1;

    logic [TW-1:0] cnt_q;
    logic          vs_q;
    logic          vs_rise;
    logic          tick;

    assign vs_rise = vsync_i & ~vs_q;
    assign tick    = clk_en_i | (vs_en_i & vs_rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            vs_q  <= 1'b0;
        end else begin
            vs_q <= vsync_i;
            if (clr_i) begin
                cnt_q <= '0;
            end else if (run_i && tick && (cnt_q != CMAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign expired_o = (limit_i != '0) && (cnt_q >= limit_i);
endmodule

// File: rtl/cmdseq_sigcopy.sv
module cmdseq_sigcopy #(
    parameter int NSIG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSIG-1:0] set_i,
    input  logic [NSIG-1:0] clr_i,
    input  logic [NSIG-1:0] live_i,
    output logic [NSIG-1:0] sig_o
);
    logic [NSIG-1:0] sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else begin
            sig_q <= ((sig_q & ~clr_i) | set_i) | live_i;
        end
    end

    assign sig_o = sig_q;
endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
#(
    parameter int NSIG = 8,
    parameter int TW   = 16,
    parameter int AW   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [AW-1:0]       start_addr_i,
    input  logic [EVW-NSIG-1:0] evt_i,
    input  logic [NSIG-1:0]     stat_i,
    input  logic                vsync_i,
    input  logic [TW-1:0]       tmo_limit_i,
    input  logic                tmo_clk_en_i,
    input  logic                tmo_vs_en_i,
    input  logic                irq_en_i,
    output logic                req_o,
    output logic [AW-1:0]       addr_o,
    input  logic [31:0]         rdata_i,
    input  logic                rvalid_i,
    output logic                upl_req_o,
    output logic [EVW-1:0]      upl_mask_o,
    input  logic                upl_done_i,
    output logic [NSIG-1:0]     sig_o,
    output logic                tmo_flag_o,
    output logic                late_flag_o,
    output logic                err_flag_o,
    output logic                irq_o,
    output logic                busy_o
);
    seq_state_t state_q, state_d;

    logic [31:0]     cmd_q;
    logic [3:0]      opc;
    logic [EVW-1:0]  ev_vec;
    logic            cond_met;
    logic            expired;
    logic            fetch_load;
    logic            fetch_adv;
    logic            cmd_load;
    logic            tmr_clr;
    logic            tmr_run;
    logic [NSIG-1:0] set_m;
    logic [NSIG-1:0] clr_m;
    logic            tmo_hit;
    logic            late_hit;
    logic            err_hit;
    logic            tmo_q, late_q, err_q, irq_q;

    assign opc    = cmd_q[31:28];
    assign ev_vec = {evt_i, sig_o};

    cmdseq_fetch #(.AW(AW)) u_fetch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (fetch_load),
        .base_i (start_addr_i),
        .adv_i  (fetch_adv),
        .addr_o (addr_o)
    );

    cmdseq_evcond #(.W(EVW)) u_cond (
        .vec_i (ev_vec),
        .sel_i (cmd_q[EVW-1:0]),
        .any_i (cmd_q[MODE_BIT]),
        .inv_i (cmd_q[INV_BIT]),
        .met_o (cond_met)
    );

    cmdseq_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .run_i     (tmr_run),
        .clk_en_i  (tmo_clk_en_i),
        .vs_en_i   (tmo_vs_en_i),
        .vsync_i   (vsync_i),
        .limit_i   (tmo_limit_i),
        .expired_o (expired)
    );

    cmdseq_sigcopy #(.NSIG(NSIG)) u_sig (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_m),
        .clr_i  (clr_m),
        .live_i (stat_i),
        .sig_o  (sig_o)
    );

    // next state and per-cycle control
    always_comb begin
        state_d    = state_q;
        fetch_load = 1'b0;
        fetch_adv  = 1'b0;
        cmd_load   = 1'b0;
        tmr_clr    = 1'b0;
        set_m      = '0;
        clr_m      = '0;
        tmo_hit    = 1'b0;
        late_hit   = 1'b0;
        err_hit    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    fetch_load = 1'b1;
                    state_d    = S_FETCH;
                end
            end
            S_FETCH: begin
                if (rvalid_i) begin
                    cmd_load  = 1'b1;
                    fetch_adv = 1'b1;
                    state_d   = S_EXEC;
                end
            end
            S_EXEC: begin
                case (opc)
                    OPC_CLR: begin
                        clr_m   = cmd_q[NSIG-1:0];
                        state_d = S_FETCH;
                    end
                    OPC_SET: begin
                        set_m   = cmd_q[NSIG-1:0];
                        state_d = S_FETCH;
                    end
                    OPC_WAIT: begin
                        tmr_clr = 1'b1;
                        state_d = S_WAIT;
                    end
                    OPC_LATE: begin
                        if (cond_met) begin
                            late_hit = 1'b1;
                            state_d  = S_FETCH;
                        end else begin
                            tmr_clr = 1'b1;
                            state_d = S_WAIT;
                        end
                    end
                    OPC_UPLD: begin
                        state_d = S_UPLD;
                    end
                    default: begin
                        err_hit = 1'b1;
                        state_d = S_IDLE;
                    end
                endcase
            end
            S_WAIT: begin
                if (cond_met) begin
                    state_d = S_FETCH;
                end else if (expired) begin
                    tmo_hit = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_UPLD: begin
                if (upl_done_i) begin
                    state_d = S_FETCH;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // command latch and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            tmo_q  <= 1'b0;
            late_q <= 1'b0;
            err_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= tmo_hit & irq_en_i;
            if (cmd_load) begin
                cmd_q <= rdata_i;
            end
            if (fetch_load) begin
                tmo_q  <= 1'b0;
                late_q <= 1'b0;
                err_q  <= 1'b0;
            end else begin
                if (tmo_hit)  tmo_q  <= 1'b1;
                if (late_hit) late_q <= 1'b1;
                if (err_hit)  err_q  <= 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        req_o       = (state_q == S_FETCH);
        upl_req_o   = (state_q == S_UPLD);
        tmr_run     = (state_q == S_WAIT);
        busy_o      = (state_q != S_IDLE);
        upl_mask_o  = cmd_q[EVW-1:0];
        tmo_flag_o  = tmo_q;
        late_flag_o = late_q;
        err_flag_o  = err_q;
        irq_o       = irq_q;
    end
endmodule

// File: rtl/cmdseq_chk.sv
module cmdseq_chk #(
    parameter int NSIG = 8,
    parameter int AW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_o,
    input logic            rvalid_i,
    input logic [AW-1:0]   addr_o,
    input logic            upl_req_o,
    input logic            upl_done_i,
    input logic [25:0]     upl_mask_o,
    input logic            irq_o,
    input logic            tmo_flag_o,
    input logic            err_flag_o,
    input logic            busy_o,
    input logic [NSIG-1:0] stat_i,
    input logic [NSIG-1:0] sig_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !rvalid_i) |=> (req_o && $stable(addr_o))); // R1
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && rvalid_i) |=> (addr_o == $past(addr_o) + AW'(4))); // R1
    AST_STAT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_i != '0) |=> ((sig_o & $past(stat_i)) == $past(stat_i))); // R3
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (tmo_flag_o && !busy_o)); // R8
    AST_TMO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag_o) |-> !busy_o); // R8
    AST_UPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upl_req_o && !upl_done_i) |=> (upl_req_o && $stable(upl_mask_o))); // R10
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_o && upl_req_o)); // R10
    AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag_o) |-> !busy_o); // R11
endmodule

bind cmdseq_top cmdseq_chk #(.NSIG(NSIG), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_o      (req_o),
    .rvalid_i   (rvalid_i),
    .addr_o     (addr_o),
    .upl_req_o  (upl_req_o),
    .upl_done_i (upl_done_i),
    .upl_mask_o (upl_mask_o),
    .irq_o      (irq_o),
    .tmo_flag_o (tmo_flag_o),
    .err_flag_o (err_flag_o),
    .busy_o     (busy_o),
    .stat_i     (stat_i),
    .sig_o      (sig_o)
);

// File: tb/cmdseq_top_tb.sv
module cmdseq_top_tb;
    localparam int NSIG = 8;
    localparam int TW   = 16;
    localparam int AW   = 32;
    localparam int NEV  = 26 - NSIG;
    localparam logic [31:0] BAD = 32'hF000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [AW-1:0]   start_addr_i = '0;
    logic [NEV-1:0]  evt_i = '0;
    logic [NSIG-1:0] stat_i = '0;
    logic            vsync_i = 1'b0;
    logic [TW-1:0]   tmo_limit_i = '0;
    logic            tmo_clk_en_i = 1'b0;
    logic            tmo_vs_en_i = 1'b0;
    logic            irq_en_i = 1'b0;
    logic            req_o;
    logic [AW-1:0]   addr_o;
    logic [31:0]     rdata_i;
    logic            rvalid_i;
    logic            upl_req_o;
    logic [25:0]     upl_mask_o;
    logic            upl_done_i;
    logic [NSIG-1:0] sig_o;
    logic            tmo_flag_o, late_flag_o, err_flag_o, irq_o, busy_o;

    int nchk = 0;
    int nfail = 0;
    int irq_cnt = 0;
    int upl_cnt = 0;
    logic [25:0] upl_seen = '0;
    logic [2:0]  ucnt;
    logic [31:0] mem [64];
    bit done = 0;

    always #2.5 clk = ~clk;

    cmdseq_top #(.NSIG(NSIG), .TW(TW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .evt_i(evt_i), .stat_i(stat_i), .vsync_i(vsync_i), .tmo_limit_i(tmo_limit_i),
        .tmo_clk_en_i(tmo_clk_en_i), .tmo_vs_en_i(tmo_vs_en_i), .irq_en_i(irq_en_i),
        .req_o(req_o), .addr_o(addr_o), .rdata_i(rdata_i), .rvalid_i(rvalid_i),
        .upl_req_o(upl_req_o), .upl_mask_o(upl_mask_o), .upl_done_i(upl_done_i),
        .sig_o(sig_o), .tmo_flag_o(tmo_flag_o), .late_flag_o(late_flag_o),
        .err_flag_o(err_flag_o), .irq_o(irq_o), .busy_o(busy_o)
    );

    // memory model: one cycle latency
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_i <= 1'b0;
            rdata_i  <= '0;
        end else begin
            rvalid_i <= req_o && !rvalid_i;
            rdata_i  <= mem[addr_o[7:2]];
        end
    end

    // upload responder: done on the fourth request cycle
    assign upl_done_i = upl_req_o && (ucnt == 3'd3);
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ucnt <= '0;
        end else if (upl_req_o) begin
            if (ucnt == 3'd0) begin
                upl_cnt  <= upl_cnt + 1;
                upl_seen <= upl_mask_o;
            end
            ucnt <= upl_done_i ? 3'd0 : ucnt + 3'd1;
        end
    end

    always @(posedge clk) if (rst_n && irq_o) irq_cnt <= irq_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = BAD;
    endtask

    task automatic go();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic vs_pulse();
        vsync_i = 1'b1;
        cyc(1);
        vsync_i = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset();
        chk("R12 busy", 32'(busy_o), 0);
        chk("R12 req", 32'(req_o), 0);
        chk("R12 sig", 32'(sig_o), 0);
        chk("R12 flags", {28'd0, tmo_flag_o, late_flag_o, err_flag_o, irq_o}, 0);
    endtask

    task automatic t_signals();
        int n;
        clear_mem();
        mem[0] = 32'h1000_000F;
        mem[1] = 32'h0000_0000;
        mem[2] = 32'h0000_0005;
        mem[3] = 32'h2000_0002;
        go(); wait_idle(n);
        chk("R2 set/clear", 32'(sig_o), 32'h0A);
        chk("R4 wait on signal bit", 32'(err_flag_o), 1);
        chk("R1 address after five words", addr_o, 32'd20);
        clear_mem();
        mem[0] = 32'h0000_0000;
        go(); wait_idle(n);
        chk("R2 no-operation", 32'(sig_o), 32'h0A);
    endtask

    task automatic t_status();
        int n;
        clear_mem();
        mem[0] = 32'h0000_0004;
        stat_i = 8'h04;
        go(); wait_idle(n);
        chk("R3 live status beats clear", 32'(sig_o), 32'h0E);
        stat_i = '0;
        go(); wait_idle(n);
        chk("R3 clear with status low", 32'(sig_o), 32'h0A);
        stat_i = 8'h04; cyc(1); stat_i = '0; cyc(2);
        chk("R3 status pulse sets copy", 32'(sig_o), 32'h0E);
    endtask

    task automatic t_and();
        int n;
        clear_mem();
        mem[0] = 32'h2000_0300;
        evt_i = '0;
        go(); cyc(30);
        chk("R4 stalls with none", 32'(busy_o && !req_o), 1);
        evt_i[0] = 1'b1; cyc(10);
        chk("R4 stalls with one of two", 32'(busy_o && !req_o), 1);
        evt_i[1] = 1'b1;
        wait_idle(n);
        chk("R4 released by all", {tmo_flag_o, err_flag_o}, 32'b01);
        chk("R7 limit zero no timeout", 32'(tmo_flag_o), 0);
    endtask

    task automatic t_or_inv();
        int n;
        clear_mem();
        mem[0] = 32'h2800_0300;
        evt_i = '0;
        go(); cyc(20);
        chk("R5 or stalls with none", 32'(busy_o), 1);
        evt_i[1] = 1'b1;
        wait_idle(n);
        chk("R5 or released by one", 32'(err_flag_o), 1);
        mem[0] = 32'h2C00_0300;
        evt_i[1:0] = 2'b11;
        go(); cyc(20);
        chk("R6 inverted stalls while true", 32'(busy_o), 1);
        evt_i[0] = 1'b0; cyc(10);
        chk("R6 inverted stalls with one left", 32'(busy_o), 1);
        evt_i[1] = 1'b0;
        wait_idle(n);
        chk("R6 inverted released when false", 32'(err_flag_o), 1);
    endtask

    task automatic t_tmo_clk();
        int n;
        clear_mem();
        mem[0] = 32'h2000_0100;
        evt_i = '0;
        tmo_limit_i = 16'd20; tmo_clk_en_i = 1'b1; tmo_vs_en_i = 1'b0; irq_en_i = 1'b1;
        irq_cnt = 0;
        go(); wait_idle(n);
        cyc(2);
        chk("R8 timeout flag", {tmo_flag_o, err_flag_o}, 32'b10);
        chk("R12 start cleared error", 32'(err_flag_o), 0);
        chk("R7 clock limit window", 32'(n >= 18 && n <= 28), 1);
        chk("R8 one irq pulse", irq_cnt, 1);
        chk("R8 stopped", 32'(busy_o), 0);
    endtask

    task automatic t_tmo_vs();
        int n;
        clear_mem();
        mem[0] = 32'h2000_0100;
        tmo_limit_i = 16'd3; tmo_clk_en_i = 1'b0; tmo_vs_en_i = 1'b1; irq_en_i = 1'b0;
        irq_cnt = 0;
        go(); cyc(4);
        vs_pulse(); vs_pulse(); cyc(20);
        chk("R7 two vsyncs not expired", {busy_o, tmo_flag_o}, 32'b10);
        vs_pulse(); wait_idle(n);
        chk("R7 third vsync expires", {busy_o, tmo_flag_o}, 32'b01);
        chk("R8 no irq when disabled", irq_cnt, 0);
        tmo_limit_i = '0; tmo_vs_en_i = 1'b0;
    endtask

    task automatic t_late();
        int n;
        clear_mem();
        mem[0] = 32'h3000_0100;
        evt_i = '0; evt_i[0] = 1'b1;
        go(); wait_idle(n);
        chk("R9 already true sets late", {late_flag_o, err_flag_o}, 32'b11);
        evt_i[0] = 1'b0;
        go(); cyc(20);
        chk("R9 false stalls and start clears late", {busy_o, late_flag_o}, 32'b10);
        evt_i[0] = 1'b1;
        wait_idle(n);
        chk("R9 released without late", {late_flag_o, err_flag_o}, 32'b01);
        evt_i = '0;
    endtask

    task automatic t_upload();
        int n;
        clear_mem();
        mem[0] = 32'h4012_3456;
        upl_cnt = 0;
        go(); wait_idle(n);
        chk("R10 upload mask", 32'(upl_seen), 32'h0012_3456);
        chk("R10 one hand-off", upl_cnt, 1);
        chk("R10 continued after done", 32'(err_flag_o), 1);
    endtask

    task automatic t_unknown();
        int n;
        clear_mem();
        mem[0] = 32'h5000_0000;
        mem[1] = 32'h1000_0080;
        go(); wait_idle(n);
        chk("R11 error flag", 32'(err_flag_o), 1);
        chk("R11 stopped after one word", addr_o, 32'd4);
        chk("R11 next word not run", 32'(sig_o[7]), 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_signals();
        t_status();
        t_and();
        t_or_inv();
        t_tmo_clk();
        t_tmo_vs();
        t_late();
        t_upload();
        t_unknown();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule